// File: doc/BRIEF.md
# Configurable Interrupt Trigger Detector

This block turns a bank of raw interrupt request lines into a latched pending vector. Each line is first brought into the local clock domain through a two-flop synchronizer. A per-source configuration of three bits then decides how the synchronized line is interpreted. The line can be a level, active high or active low. It can be an edge that latches: rising only, falling only, or either direction.

Level sources make their pending bit follow the synchronized line, inverted when the source is active low. Edge sources compare the synchronized line with a stored copy of its previous value. A detected edge sets the pending bit, and the bit stays set until a clear vector removes it. The stored previous-level vector is updated every cycle whatever the mode, and it is brought out so the surrounding controller can observe line state. Register decoding and routing of pending bits to processor interrupt outputs belong to the surrounding controller.

The reset is asynchronous and active low. It is expected to be released synchronously to `clk` by the reset network of the chip.

Top module: `irq_trigger_detect`

## Requirements
- R1: While `rst_n` is low, `pending_o` and `level_o` are all zeros.
- R2: A source with `level_mode_i`=1 and `polarity_i`=1 has its `pending_o` bit equal to its line. A line value present at clock edge k is visible on `pending_o` after edge k+2, which is two synchronizer flops followed by one result register.
- R3: A source with `level_mode_i`=1 and `polarity_i`=0 has its `pending_o` bit equal to the inverse of its line, with the same latency as R2.
- R4: A source with `level_mode_i`=0 and `both_edge_i`=1 sets its `pending_o` bit on any change of the synchronized line, in either direction.
- R5: A source with `level_mode_i`=0 and `both_edge_i`=0 sets its bit on a rising edge when `polarity_i`=1 and on a falling edge when `polarity_i`=0. The edge of the other direction leaves the bit unchanged.
- R6: An edge source's pending bit stays set until a cycle in which its `clear_i` bit is 1. It is then 0 after that clock edge.
- R7: When an edge is detected on an edge source in the same cycle as its `clear_i` bit is 1, the pending bit ends that cycle set.
- R8: `clear_i` has no effect on level sources. Their pending bits keep following the line.
- R9: `level_o` holds the synchronized line value of the previous cycle for every source, in every mode. A line value at edge k appears on `level_o` after edge k+2. The stored vector resets to zero, so a line that is high as reset is released is seen as a rising edge.
- R10: All `NUM_SRC` (default 51) sources, numbered 0 to 50, are handled independently, and the highest-numbered source behaves like the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | NUM_SRC | Raw interrupt lines, asynchronous |
| level_mode_i | input | NUM_SRC | 1: level source, 0: edge source |
| both_edge_i | input | NUM_SRC | For edge sources: 1 detects both directions |
| polarity_i | input | NUM_SRC | Level: 1 active high. Single edge: 1 rising, 0 falling |
| clear_i | input | NUM_SRC | One-cycle clear for latched edge pending bits |
| pending_o | output | NUM_SRC | Raw pending vector |
| level_o | output | NUM_SRC | Stored previous synchronized line level |

## Verification
The bench drives a clear and a new edge into the same cycle. A design that gives the clear priority would lose that interrupt. It also pulses clear on level sources, where a wrong design would drop an asserted level bit, and it checks that an edge of the unselected direction does not latch on single-edge sources. A cycle-accurate random phase keeps changing modes while lines toggle. In that phase, a wrong synchronizer depth would show as a latency error. If the previous-level register were updated only in edge mode, a stale comparison would produce a false edge after a mode switch.

// File: rtl/irqtd_pkg.sv
package irqtd_pkg;

  typedef enum logic [2:0] {
    TM_LVL_LOW  = 3'd0,
    TM_LVL_HIGH = 3'd1,
    TM_EDGE_FALL = 3'd2,
    TM_EDGE_RISE = 3'd3,
    TM_EDGE_ANY  = 3'd4
  } trig_mode_e;

  function automatic trig_mode_e decode_mode(input logic lvl, input logic both,
                                             input logic pol);
    trig_mode_e m;
    if (lvl)       m = pol ? TM_LVL_HIGH : TM_LVL_LOW;
    else if (both) m = TM_EDGE_ANY;
    else           m = pol ? TM_EDGE_RISE : TM_EDGE_FALL;
    return m;
  endfunction

endpackage

// File: rtl/irqtd_sync.sv
module irqtd_sync #(
  parameter int WIDTH  = 51,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = async_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/irqtd_source.sv
module irqtd_source
  import irqtd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic lvl_mode_i,
  input  logic both_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic pend_o,
  output logic prev_o
);

  logic       pend_q, pend_d;
  logic       prev_q;
  logic       rise, fall, hit;
  trig_mode_e mode;

  assign rise = sync_i & ~prev_q;
  assign fall = ~sync_i & prev_q;
  assign mode = decode_mode(lvl_mode_i, both_i, pol_i);

  always_comb begin
    hit = 1'b0;
    unique case (mode)
      TM_EDGE_RISE: hit = rise;
      TM_EDGE_FALL: hit = fall;
      TM_EDGE_ANY:  hit = rise | fall;
      default:      hit = 1'b0;
    endcase
  end

  // Level sources track the line; edge sources latch, a fresh edge beats clear.
  always_comb begin
    unique case (mode)
      TM_LVL_HIGH: pend_d = sync_i;
      TM_LVL_LOW:  pend_d = ~sync_i;
      default:     pend_d = hit | (pend_q & ~clr_i);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      prev_q <= sync_i;
    end
  end

  assign pend_o = pend_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/irq_trigger_detect.sv
module irq_trigger_detect #(
  parameter int NUM_SRC     = 51,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] line_i,
  input  logic [NUM_SRC-1:0] level_mode_i,
  input  logic [NUM_SRC-1:0] both_edge_i,
  input  logic [NUM_SRC-1:0] polarity_i,
  input  logic [NUM_SRC-1:0] clear_i,
  output logic [NUM_SRC-1:0] pending_o,
  output logic [NUM_SRC-1:0] level_o
);

  logic [NUM_SRC-1:0] line_sync;

  irqtd_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(line_i),
    .sync_o (line_sync)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    irqtd_source i_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_i    (line_sync[i]),
      .lvl_mode_i(level_mode_i[i]),
      .both_i    (both_edge_i[i]),
      .pol_i     (polarity_i[i]),
      .clr_i     (clear_i[i]),
      .pend_o    (pending_o[i]),
      .prev_o    (level_o[i])
    );
  end

endmodule

// File: rtl/irqtd_checker.sv
module irqtd_checker #(
  parameter int NUM_SRC = 51
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] line_i,
  input logic [NUM_SRC-1:0] level_mode_i,
  input logic [NUM_SRC-1:0] both_edge_i,
  input logic [NUM_SRC-1:0] polarity_i,
  input logic [NUM_SRC-1:0] clear_i,
  input logic [NUM_SRC-1:0] pending_o,
  input logic [NUM_SRC-1:0] level_o,
  input logic [NUM_SRC-1:0] line_sync
);

  // R1: outputs cleared while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_zero: assert (pending_o == '0 && level_o == '0)
        else $error("a_r1_reset_zero");
    end
  end

  // R9: stored level is the line three edges earlier
  a_r9_level_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 3) && $past(rst_n, 2) && $past(rst_n)) |-> level_o == $past(line_i, 3));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    // R2, R3, R8: level sources follow the synchronized line, clear ignored
    a_r8_level_track: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(level_mode_i[i])) |->
        pending_o[i] == ($past(polarity_i[i]) ? $past(line_sync[i]) : ~$past(line_sync[i])));

    // R6: edge pending bit holds without clear
    a_r6_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!level_mode_i[i] && !clear_i[i] && pending_o[i])) |-> pending_o[i]);

    // R4, R7: any-edge source with a change ends set even with clear
    a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!level_mode_i[i] && both_edge_i[i] &&
                             (line_sync[i] != level_o[i]))) |-> pending_o[i]);
  end

endmodule

bind irq_trigger_detect irqtd_checker #(.NUM_SRC(NUM_SRC)) i_irqtd_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_i      (line_i),
  .level_mode_i(level_mode_i),
  .both_edge_i (both_edge_i),
  .polarity_i  (polarity_i),
  .clear_i     (clear_i),
  .pending_o   (pending_o),
  .level_o     (level_o),
  .line_sync   (line_sync)
);

// File: tb/test_irq_trigger_detect.sv
module test_irq_trigger_detect;
  localparam int N = 51;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] line_i = '0, level_mode_i = '0, both_edge_i = '0;
  logic [N-1:0] polarity_i = '0, clear_i = '0;
  logic [N-1:0] pending_o, level_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_trigger_detect #(.NUM_SRC(N)) i_irq_trigger_detect (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .level_mode_i(level_mode_i),
    .both_edge_i(both_edge_i), .polarity_i(polarity_i), .clear_i(clear_i),
    .pending_o(pending_o), .level_o(level_o));

  // Reference model built from the requirements
  logic [N-1:0] m_s1, m_s2, m_lvl, m_pend;

  function automatic logic [N-1:0] exp_next(input logic [N-1:0] pend, s, prev,
      lvl, both, pol, clr);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      logic hit;
      if (both[i])     hit = s[i] ^ prev[i];
      else if (pol[i]) hit = s[i] & ~prev[i];
      else             hit = ~s[i] & prev[i];
      if (lvl[i]) r[i] = pol[i] ? s[i] : ~s[i];
      else        r[i] = hit | (pend[i] & ~clr[i]);
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_lvl <= '0; m_pend <= '0;
    end else begin
      m_s1 <= line_i;
      m_s2 <= m_s1;
      m_lvl <= m_s2;
      m_pend <= exp_next(m_pend, m_s2, m_lvl, level_mode_i, both_edge_i,
                         polarity_i, clear_i);
    end
  end

  task automatic chk_bit(input int idx, input logic exp, input string tag);
    checks++;
    if (pending_o[idx] !== exp) begin
      errors++;
      $display("FAIL %s bit %0d: got %b expected %b", tag, idx, pending_o[idx], exp);
    end
  endtask

  task automatic chk_vec(input logic [N-1:0] act, input logic [N-1:0] exp,
                         input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [N-1:0] rnd();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[N-1:0];
  endfunction

  initial begin
    int seed;
    seed = $urandom(32'h1bad5eed);
    // bit0 level-high, bit1 level-low, bit2 any edge, bit3 rise, bit4 fall, bit50 rise
    level_mode_i = '0; level_mode_i[0] = 1; level_mode_i[1] = 1;
    polarity_i = '0; polarity_i[0] = 1; polarity_i[3] = 1; polarity_i[50] = 1;
    both_edge_i = '0; both_edge_i[2] = 1;
    line_i = '0;
    repeat (3) @(negedge clk);
    chk_vec(pending_o, '0, "R1 pending in reset");
    chk_vec(level_o, '0, "R1 level in reset");
    rst_n = 1'b1;
    settle();
    chk_bit(1, 1'b1, "R3 active-low idle");
    chk_bit(0, 1'b0, "R2 active-high idle");
    chk_bit(4, 1'b0, "R5 no falling edge yet");

    line_i[0] = 1; line_i[2] = 1; line_i[3] = 1; line_i[4] = 1; line_i[50] = 1;
    @(negedge clk); @(negedge clk);
    chk_bit(0, 1'b0, "R2 latency not yet");
    @(negedge clk);
    chk_bit(0, 1'b1, "R2 high level");
    chk_bit(1, 1'b1, "R3 low level, own line low");
    chk_bit(2, 1'b1, "R4 rising on any-edge");
    chk_bit(3, 1'b1, "R5 rising");
    chk_bit(4, 1'b0, "R5 rising ignored on falling source");
    chk_bit(50, 1'b1, "R10 top source");
    checks++;
    if (level_o[50] !== 1'b1 || level_o[0] !== 1'b1) begin
      errors++; $display("FAIL R9 level_o %h expected bits 0,50 set", level_o);
    end

    line_i = '0; line_i[1] = 1;
    settle();
    chk_bit(0, 1'b0, "R2 released");
    chk_bit(1, 1'b0, "R3 line high deasserts");
    chk_bit(3, 1'b1, "R6 rise stays latched");
    chk_bit(4, 1'b1, "R5 falling");
    chk_bit(2, 1'b1, "R6 any-edge held");

    line_i[0] = 1; line_i[1] = 0;
    settle();
    clear_i = '1;
    @(negedge clk);
    clear_i = '0;
    chk_bit(0, 1'b1, "R8 clear ignored level-high");
    chk_bit(1, 1'b1, "R8 clear ignored level-low");
    chk_bit(2, 1'b0, "R6 cleared any-edge");
    chk_bit(3, 1'b0, "R6 cleared rise");
    chk_bit(4, 1'b0, "R6 cleared fall");
    chk_bit(50, 1'b0, "R10 top source cleared");

    // R7: edge arrives in the cycle clear is high
    line_i[2] = 1; line_i[3] = 1;
    @(negedge clk); @(negedge clk);
    clear_i[2] = 1; clear_i[3] = 1;
    @(negedge clk);
    clear_i = '0;
    chk_bit(2, 1'b1, "R7 edge beats clear any-edge");
    chk_bit(3, 1'b1, "R7 edge beats clear rise");
    @(negedge clk);
    chk_bit(3, 1'b1, "R6 hold after collision");

    // Random phase, cycle-accurate against the model
    for (int c = 0; c < 3000; c++) begin
      if (c % 40 == 0) begin
        level_mode_i = rnd(); both_edge_i = rnd(); polarity_i = rnd();
      end
      line_i = rnd() & rnd() | (line_i & rnd());
      clear_i = rnd() & rnd();
      @(negedge clk);
      chk_vec(pending_o, m_pend, "R10 random pending");
      chk_vec(level_o, m_lvl, "R9 random level");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule